// File: doc/BRIEF.md
# Masked Alarm and Increment Interrupt Unit

This unit watches the eight calendar fields of a real-time clock (seconds, minutes, hours, day of month, day of week, day of year, month and year). It raises an interrupt in two situations. The first is when the live field values agree with a programmed alarm time. The second is when one of a chosen set of fields advances. The counters themselves live elsewhere. The unit receives their current values as one flat bus and receives one advance strobe per field.

Software programs one alarm value per field. A mask has one bit per field, and each set bit removes that field from the comparison. A second bit vector selects which field advances are interrupt sources. Both sources record into a two-bit status word. Software clears each status bit by writing a 1 to it. The interrupt line is high while either status bit is set. The alarm records only the start of a match, so a match that lasts many cycles produces one event. If every field is masked, the alarm never fires.

The register interface is a simple single-cycle write strobe with a combinational read. Register offsets: status 0x00, advance-enable 0x0C, mask 0x10, alarm values at 0x60 + 4*i.

Top module: `cal_alarm_irq`

## Requirements
- R1: After reset the status word reads 0 and irq is low. The mask (offset 0x10) reads 0xFF, the advance-enable word (offset 0x0C) reads 0, and every alarm value reads 0.
- R2: Field index i has a readable and writable alarm value at offset 0x60 + 4*i. The field order is 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 day of week, 5 day of year, 6 month, 7 year. Field i occupies cur_fields bits [12*i+11 : 12*i]. Only the low 12 bits of a write are kept.
- R3: The alarm status bit (bit 1 of offset 0x00) is set one clock edge after a cycle in which every unmasked field equals its alarm value and the previous cycle did not match.
- R4: A set mask bit i removes field i from the comparison, using the same bit order as R2. A clear bit keeps the field in the comparison. A change to a masked field neither starts nor breaks a match.
- R5: A match that persists sets the alarm status bit only once. Once cleared, the bit stays clear until the fields first stop matching and then match again.
- R6: While the mask is 0xFF, the alarm status bit never sets, even when every field equals its alarm value.
- R7: When inc_stb[i] is high and advance-enable bit i is set, the advance status bit (bit 0 of offset 0x00) sets one clock edge later. A strobe whose enable bit is clear has no effect.
- R8: Writing offset 0x00 clears each status bit whose written bit is 1 and leaves the other bits unchanged. A set event in the same cycle as a clear of the same bit wins.
- R9: irq is high exactly when at least one status bit is set, and it changes in the same cycle as the status word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_fields | input | NF*FIELD_W (96) | Live calendar field values, field i in slot i |
| inc_stb | input | NF (8) | One-cycle advance strobe per field |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte offset |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Combinational read data for reg_addr |
| irq | output | 1 | Interrupt request, OR of the status bits |

## Verification
A register write takes effect at the edge that samples it, and reads are combinational. A mask write that creates a match therefore shows in the status word one edge after the write edge. A field change or strobe shows one edge after the cycle in which it is presented. The bench drives every input on the falling edge and reads the status at the next falling edge, after exactly one rising edge. For the rising-edge and write-effect cases it waits one falling edge more. Before several of those edges it also reads the status to confirm that nothing appears early.

// File: rtl/cal_irq_pkg.sv
`timescale 1ns/1ps
package cal_irq_pkg;

    localparam int unsigned REG_ADDR_W = 7;

    localparam logic [REG_ADDR_W-1:0] OFS_STATUS = 7'h00;
    localparam logic [REG_ADDR_W-1:0] OFS_INC_EN = 7'h0C;
    localparam logic [REG_ADDR_W-1:0] OFS_MASK   = 7'h10;
    localparam logic [REG_ADDR_W-1:0] OFS_ALARM0 = 7'h60;

    localparam int unsigned ST_INCR_BIT  = 0;
    localparam int unsigned ST_ALARM_BIT = 1;

    typedef struct packed {
        logic alarm;
        logic incr;
    } irq_flags_t;

    // True when the offset names one of nf word-aligned alarm slots
    function automatic logic is_alarm_slot(input logic [REG_ADDR_W-1:0] a,
                                           input int unsigned nf);
        int unsigned ai;
        ai = int'(a);
        return (ai >= int'(OFS_ALARM0)) && (ai < int'(OFS_ALARM0) + 4 * nf)
               && (a[1:0] == 2'b00);
    endfunction

endpackage

// File: rtl/cal_irq_regs.sv
`timescale 1ns/1ps
module cal_irq_regs
    import cal_irq_pkg::*;
#(
    parameter int unsigned NF      = 8,
    parameter int unsigned FIELD_W = 12,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_wr,
    input  logic [REG_ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    input  irq_flags_t               flags,
    output logic [DATA_W-1:0]        reg_rdata,
    output logic [NF*FIELD_W-1:0]    alarm_flat,
    output logic [NF-1:0]            mask_q,
    output logic [NF-1:0]            en_q,
    output logic [1:0]               clr_req
);
    localparam int unsigned IDX_W = (NF > 1) ? $clog2(NF) : 1;

    logic [REG_ADDR_W-1:0] ofs;
    logic [IDX_W-1:0]      slot;
    logic                  hit_alarm;
    logic [FIELD_W-1:0]    alarm_q [NF];

    assign ofs       = reg_addr - OFS_ALARM0;
    assign slot      = ofs[IDX_W+1:2];
    assign hit_alarm = is_alarm_slot(reg_addr, NF);

    logic unused_bits;
    assign unused_bits = ^{ofs[1:0], ofs[REG_ADDR_W-1:IDX_W+2], reg_wdata[DATA_W-1:FIELD_W]};

    for (genvar g = 0; g < NF; g++) begin : g_alarm
        always_ff @(posedge clk) begin
            if (rst) begin
                alarm_q[g] <= '0;
            end else if (reg_wr && hit_alarm && slot == IDX_W'(g)) begin
                alarm_q[g] <= reg_wdata[FIELD_W-1:0];
            end
        end
        assign alarm_flat[g*FIELD_W +: FIELD_W] = alarm_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            en_q   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFS_MASK)   mask_q <= reg_wdata[NF-1:0];
            if (reg_addr == OFS_INC_EN) en_q   <= reg_wdata[NF-1:0];
        end
    end

    assign clr_req = (reg_wr && reg_addr == OFS_STATUS) ? reg_wdata[1:0] : 2'b00;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_STATUS) begin
            reg_rdata[ST_ALARM_BIT] = flags.alarm;
            reg_rdata[ST_INCR_BIT]  = flags.incr;
        end else if (reg_addr == OFS_INC_EN) begin
            reg_rdata[NF-1:0] = en_q;
        end else if (reg_addr == OFS_MASK) begin
            reg_rdata[NF-1:0] = mask_q;
        end else if (hit_alarm) begin
            reg_rdata[FIELD_W-1:0] = alarm_q[slot];
        end
    end

endmodule

// File: rtl/cal_alarm_match.sv
`timescale 1ns/1ps
module cal_alarm_match #(
    parameter int unsigned NF      = 8,
    parameter int unsigned FIELD_W = 12
) (
    input  logic [NF*FIELD_W-1:0] cur_fields,
    input  logic [NF*FIELD_W-1:0] alarm_flat,
    input  logic [NF-1:0]         mask_q,
    output logic                  match_now
);
    logic [NF-1:0] field_ok;

    for (genvar g = 0; g < NF; g++) begin : g_cmp
        assign field_ok[g] = mask_q[g] |
            (cur_fields[g*FIELD_W +: FIELD_W] == alarm_flat[g*FIELD_W +: FIELD_W]);
    end

    // A fully masked compare is treated as "alarm off", never as a match
    assign match_now = (&field_ok) & ~(&mask_q);

endmodule

// File: rtl/cal_irq_flags.sv
`timescale 1ns/1ps
module cal_irq_flags
    import cal_irq_pkg::*;
#(
    parameter int unsigned NF = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          match_now,
    input  logic [NF-1:0] inc_stb,
    input  logic [NF-1:0] en_q,
    input  logic [1:0]    clr_req,
    output irq_flags_t    flags,
    output logic          match_d
);
    logic inc_hit;
    logic match_rise;

    assign inc_hit    = |(inc_stb & en_q);
    assign match_rise = match_now & ~match_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_d     <= 1'b0;
            flags.alarm <= 1'b0;
            flags.incr  <= 1'b0;
        end else begin
            match_d     <= match_now;
            flags.alarm <= (flags.alarm & ~clr_req[ST_ALARM_BIT]) | match_rise;
            flags.incr  <= (flags.incr  & ~clr_req[ST_INCR_BIT])  | inc_hit;
        end
    end

endmodule

// File: rtl/cal_alarm_irq.sv
`timescale 1ns/1ps
module cal_alarm_irq
    import cal_irq_pkg::*;
#(
    parameter int unsigned NF      = 8,
    parameter int unsigned FIELD_W = 12,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NF*FIELD_W-1:0] cur_fields,
    input  logic [NF-1:0]         inc_stb,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  irq
);
    irq_flags_t            flags;
    logic [NF*FIELD_W-1:0] alarm_flat;
    logic [NF-1:0]         mask_q;
    logic [NF-1:0]         en_q;
    logic [1:0]            clr_req;
    logic                  match_now;
    logic                  match_d;
    logic                  alarm_flag;
    logic                  incr_flag;

    cal_irq_regs #(.NF(NF), .FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .flags      (flags),
        .reg_rdata  (reg_rdata),
        .alarm_flat (alarm_flat),
        .mask_q     (mask_q),
        .en_q       (en_q),
        .clr_req    (clr_req)
    );

    cal_alarm_match #(.NF(NF), .FIELD_W(FIELD_W)) u_match (
        .cur_fields (cur_fields),
        .alarm_flat (alarm_flat),
        .mask_q     (mask_q),
        .match_now  (match_now)
    );

    cal_irq_flags #(.NF(NF)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .match_now (match_now),
        .inc_stb   (inc_stb),
        .en_q      (en_q),
        .clr_req   (clr_req),
        .flags     (flags),
        .match_d   (match_d)
    );

    assign alarm_flag = flags.alarm;
    assign incr_flag  = flags.incr;
    assign irq        = alarm_flag | incr_flag;

endmodule

// File: rtl/cal_alarm_irq_chk.sv
`timescale 1ns/1ps
module cal_alarm_irq_chk
    import cal_irq_pkg::*;
#(
    parameter int unsigned NF = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  irq,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic [1:0]            status_view,
    input logic                  match_now,
    input logic                  match_d,
    input logic                  alarm_flag,
    input logic                  incr_flag,
    input logic [NF-1:0]         inc_stb,
    input logic [NF-1:0]         en_q,
    input logic [NF-1:0]         mask_q
);
    // R3
    alarm_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (match_now && !match_d) |=> alarm_flag);

    // R5
    no_retrigger_chk: assert property (@(posedge clk) disable iff (rst)
        (!alarm_flag && match_d) |=> !alarm_flag);

    // R6
    all_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '1 && !alarm_flag) |=> !alarm_flag);

    // R7
    incr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|(inc_stb & en_q)) |=> incr_flag);

    // R9
    irq_view_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_STATUS) |-> (irq == (status_view != 2'b00)));

endmodule

bind cal_alarm_irq cal_alarm_irq_chk #(.NF(NF)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq         (irq),
    .reg_addr    (reg_addr),
    .status_view (reg_rdata[1:0]),
    .match_now   (match_now),
    .match_d     (match_d),
    .alarm_flag  (alarm_flag),
    .incr_flag   (incr_flag),
    .inc_stb     (inc_stb),
    .en_q        (en_q),
    .mask_q      (mask_q)
);

// File: tb/sim_cal_alarm_irq.sv
`timescale 1ns/1ps
module sim_cal_alarm_irq;
    localparam int NF = 8;
    localparam int FW = 12;
    localparam logic [6:0] A_ST = 7'h00, A_EN = 7'h0C, A_MK = 7'h10, A_AL = 7'h60;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NF*FW-1:0] cur_fields;
    logic [NF-1:0] inc_stb = '0;
    logic          reg_wr = 1'b0;
    logic [6:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    logic [FW-1:0] fv [NF];
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    always_comb for (int i = 0; i < NF; i++) cur_fields[i*FW +: FW] = fv[i];

    cal_alarm_irq u0 (
        .clk(clk), .rst(rst), .cur_fields(cur_fields), .inc_stb(inc_stb),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk_st(input string req, input logic [1:0] exp);
        logic [31:0] d;
        rd(A_ST, d);
        chk(req, d, {30'd0, exp});
        chk({req, " irq (R9)"}, {31'd0, irq}, {31'd0, exp != 2'b00});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk_st("R1 status after reset", 2'b00);
        rd(A_MK, d); chk("R1 mask reset", d, 32'hFF);
        rd(A_EN, d); chk("R1 enable reset", d, 32'h0);
        rd(A_AL, d); chk("R1 alarm slot0 reset", d, 32'h0);
        rd(A_AL + 7'h1C, d); chk("R1 alarm slot7 reset", d, 32'h0);
    endtask

    task automatic t_alarm_regs();
        logic [31:0] d;
        for (int i = 0; i < NF; i++) wr(A_AL + 7'(4*i), 32'(fv[i]));
        for (int i = 0; i < NF; i++) begin
            rd(A_AL + 7'(4*i), d);
            chk($sformatf("R2 alarm slot %0d readback", i), d, 32'(fv[i]));
        end
        wr(A_AL + 7'h1C, 32'h0000ABCD);
        rd(A_AL + 7'h1C, d); chk("R2 year truncated to 12 bits", d, 32'hBCD);
        wr(A_AL + 7'h1C, 32'd2024);
        chk_st("R2 no alarm while masked", 2'b00);
    endtask

    task automatic t_full_match();
        fv[0] = 12'd31;
        wr(A_MK, 32'h0);
        @(negedge clk);
        chk_st("R3 seconds differ no alarm", 2'b00);
        fv[0] = 12'd30;
        chk_st("R3 not set before edge", 2'b00);
        @(negedge clk);
        chk_st("R3 full match sets alarm", 2'b10);
    endtask

    task automatic t_once();
        wr(A_ST, 32'h2);
        chk_st("R8 alarm cleared by W1C", 2'b00);
        repeat (3) @(negedge clk);
        chk_st("R5 persistent match no retrigger", 2'b00);
        fv[0] = 12'd31;
        @(negedge clk);
        fv[0] = 12'd30;
        @(negedge clk);
        chk_st("R5 new match after mismatch sets", 2'b10);
        wr(A_ST, 32'h2);
    endtask

    task automatic t_mask();
        fv[0] = 12'd31;
        @(negedge clk);
        chk_st("R4 unmasked seconds mismatch", 2'b00);
        wr(A_MK, 32'h01);
        @(negedge clk);
        chk_st("R4 masked seconds allows match", 2'b10);
        wr(A_ST, 32'h2);
        wr(A_MK, 32'h81);
        fv[7] = 12'd2025;
        repeat (2) @(negedge clk);
        chk_st("R4 masked year change no effect", 2'b00);
        fv[7] = 12'd2024;
        fv[0] = 12'd30;
    endtask

    task automatic t_all_masked();
        wr(A_MK, 32'hFF);
        wr(A_ST, 32'h3);
        for (int k = 0; k < 4; k++) begin
            fv[1] = 12'd16;
            @(negedge clk);
            fv[1] = 12'd15;
            @(negedge clk);
        end
        chk_st("R6 all masked never sets", 2'b00);
    endtask

    task automatic t_incr();
        inc_stb = 8'hFF;
        @(negedge clk);
        inc_stb = 8'h00;
        chk_st("R7 strobes with no enable ignored", 2'b00);
        wr(A_EN, 32'h04);
        inc_stb = 8'h08;
        @(negedge clk);
        inc_stb = 8'h00;
        chk_st("R7 strobe on disabled field ignored", 2'b00);
        inc_stb = 8'h04;
        @(negedge clk);
        inc_stb = 8'h00;
        chk_st("R7 enabled hours strobe sets", 2'b01);
    endtask

    task automatic t_w1c();
        wr(A_MK, 32'h00);
        @(negedge clk);
        chk_st("R8 both flags set", 2'b11);
        wr(A_ST, 32'h0);
        chk_st("R8 writing zero keeps flags", 2'b11);
        wr(A_ST, 32'h1);
        chk_st("R8 clear only advance flag", 2'b10);
        reg_wr = 1'b1; reg_addr = A_ST; reg_wdata = 32'h1; inc_stb = 8'h04;
        @(negedge clk);
        reg_wr = 1'b0; inc_stb = 8'h00;
        chk_st("R8 set wins over clear", 2'b11);
        wr(A_ST, 32'h3);
        chk_st("R8 clear both, irq low", 2'b00);
    endtask

    initial begin
        fv[0] = 12'd30; fv[1] = 12'd15; fv[2] = 12'd9;   fv[3] = 12'd12;
        fv[4] = 12'd3;  fv[5] = 12'd200; fv[6] = 12'd5;  fv[7] = 12'd2024;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_alarm_regs();
        t_full_match();
        t_once();
        t_mask();
        t_all_masked();
        t_incr();
        t_w1c();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule